// File: doc/BRIEF.md
# Wired-AND Bitwise Bus Arbiter Node

This block is the arbitration and transmit engine of one node on a master-less serial bus. The bus has a shared clock line and a shared open-drain data line. The data line is a wired-AND: a node pulls it low by asserting `drive_low_o`, and the line reads 1 only when no node pulls it. Several nodes can contend for the bus at once. Each contender sends a start bit and then its node number. It drops out on the first bit where it sends recessive (1) and reads back dominant (0). The remaining node wins, which means the lowest number wins. The winner never learns that a contest took place and goes straight on to send its payload.

Every node counts the bits of each message, whether it is sending or listening. This keeps all nodes in agreement on when the bus becomes idle again. A node that loses, or whose request arrives while the bus is busy, keeps its request pending. It contends again at the next idle period without any help from its user. Both lines are brought into the local clock domain through two-flop synchronizers. Bits change after a falling bus-clock edge and are sampled on the rising edge.

Top module: `wired_and_arbiter`

## Requirements
- R1: After reset all status outputs are low and `drive_low_o` is low. The bus is treated as idle only after IDLE_BITS sampled recessive bit periods.
- R2: A message is MSG_BITS = 1+ID_W+DATA_W bits long: a 0 start bit, then `id_i` MSB first, then the latched payload MSB first. Each bit is driven after a falling edge of the bus clock and is valid at the next rising edge. `drive_low_o`=1 pulls the line to 0.
- R3: When several nodes launch together, the one with the numerically lowest id sends its complete message. That node then gives exactly one `done_o` pulse, after the last bit has been sampled.
- R4: A node that reads 0 while sending 1 in the start or id part releases the line on that bit. It gives one `lost_o` pulse and no `done_o`. At most one of `done_o`, `lost_o` and `err_o` is high in any cycle.
- R5: A losing node keeps its request and payload. It launches again at the next idle period without a new `req_i`, so pending nodes are served in ascending id order.
- R6: A node that samples a start bit it did not send does not drive the line until that message has ended and the bus is idle again.
- R7: When a request is pending at the end of a message, the next start bit follows exactly IDLE_BITS recessive bit periods after the last bit.
- R8: `won_o` is high from the last id bit until the end of the payload, and only in the winning node. Winning adds no bits to the message.
- R9: If a payload bit sent as 1 reads back as 0, the node releases the line and pulses `err_o`. It keeps its request and sends the message again later.
- R10: A `req_i` that arrives while a request is already pending is ignored. The payload latched by the first request is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Sensed data line level (asynchronous) |
| req_i | input | 1 | Request strobe; latches `data_i` when no request is pending |
| id_i | input | ID_W | Unique node number; lower wins |
| data_i | input | DATA_W | Payload word |
| drive_low_o | output | 1 | Pull the data line low |
| won_o | output | 1 | Arbitration won, payload in progress |
| lost_o | output | 1 | One-cycle pulse on arbitration loss |
| done_o | output | 1 | One-cycle pulse when own message completed |
| err_o | output | 1 | One-cycle pulse on payload read-back mismatch |

## Verification
The hardest situations to reach are the chains of losses and relaunches, where each loser must come back after exactly the idle gap and lose again to the next lower id. The payload collision is also hard to reach, because unique ids exclude it. The bench wires three nodes into a modelled wired-AND line. It fires random subsets of them together with random distinct ids and follows the whole chain of messages. To force a payload collision, it gives two nodes the same id and opposite payloads.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    BUS_WAIT = 2'd0,
    BUS_IDLE = 2'd1,
    BUS_BUSY = 2'd2
  } bus_state_t;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  // lines idle high, so reset to recessive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= '1;
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/arb_edge.sv
module arb_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b1;
    else         scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/arb_bus_mon.sv
module arb_bus_mon
  import arb_pkg::*;
#(
  parameter int MSG_BITS  = 13,
  parameter int IDLE_BITS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic bit_i,
  output logic idle_o
);
  localparam int MAXC = (MSG_BITS > IDLE_BITS) ? MSG_BITS : IDLE_BITS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] MSG_LAST  = CW'(MSG_BITS - 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_BITS - 1);

  bus_state_t    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= BUS_WAIT;
      cnt <= '0;
    end else if (rise_i) begin
      unique case (st)
        BUS_WAIT: begin
          if (!bit_i)                cnt <= '0;
          else if (cnt == IDLE_LAST) begin st <= BUS_IDLE; cnt <= '0; end
          else                       cnt <= cnt + CW'(1);
        end
        BUS_IDLE: begin
          if (!bit_i) begin st <= BUS_BUSY; cnt <= CW'(1); end
        end
        default: begin
          if (cnt == MSG_LAST) begin st <= BUS_WAIT; cnt <= '0; end
          else                       cnt <= cnt + CW'(1);
        end
      endcase
    end
  end

  assign idle_o = (st == BUS_IDLE);
endmodule

// File: rtl/arb_tx.sv
module arb_tx #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              bit_i,
  input  logic              idle_i,
  input  logic              req_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              drive_low_o,
  output logic              won_o,
  output logic              lost_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int MSG_BITS = 1 + ID_W + DATA_W;
  localparam int CW       = $clog2(MSG_BITS + 1);
  localparam logic [CW-1:0] MSG_LAST = CW'(MSG_BITS - 1);
  localparam logic [CW-1:0] ARB_LAST = CW'(ID_W);

  logic                pend, run, adv;
  logic [DATA_W-1:0]   pay;
  logic [MSG_BITS-1:0] sh;
  logic [CW-1:0]       idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend <= 1'b0; run <= 1'b0; adv <= 1'b0;
      pay <= '0; sh <= '1; idx <= '0;
      drive_low_o <= 1'b0; won_o <= 1'b0;
      lost_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      lost_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (!run) begin
        if (fall_i && idle_i && pend) begin
          run <= 1'b1; adv <= 1'b0; idx <= '0;
          sh  <= {1'b0, id_i, pay};
          drive_low_o <= 1'b1;
        end
      end else if (rise_i) begin
        if (sh[MSG_BITS-1] && !bit_i) begin
          // recessive sent, dominant read: back off at once
          run <= 1'b0; adv <= 1'b0; drive_low_o <= 1'b0; won_o <= 1'b0;
          if (idx <= ARB_LAST) lost_o <= 1'b1;
          else                 err_o  <= 1'b1;
        end else if (idx == MSG_LAST) begin
          run <= 1'b0; drive_low_o <= 1'b0; won_o <= 1'b0;
          done_o <= 1'b1; pend <= 1'b0;
        end else begin
          idx <= idx + CW'(1);
          adv <= 1'b1;
          if (idx == ARB_LAST) won_o <= 1'b1;
        end
      end else if (fall_i && adv) begin
        sh <= {sh[MSG_BITS-2:0], 1'b1};
        drive_low_o <= ~sh[MSG_BITS-2];
        adv <= 1'b0;
      end
      // a request already pending wins over a new one
      if (req_i && !pend) begin
        pend <= 1'b1;
        pay  <= data_i;
      end
    end
  end
endmodule

// File: rtl/wired_and_arbiter.sv
module wired_and_arbiter #(
  parameter int ID_W        = 4,
  parameter int DATA_W      = 8,
  parameter int IDLE_BITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              req_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              drive_low_o,
  output logic              won_o,
  output logic              lost_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int MSG_BITS = 1 + ID_W + DATA_W;

  logic [1:0] line_s;
  logic       rise, fall, bus_idle;

  arb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  arb_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (line_s[1]),
    .rise_o(rise),
    .fall_o(fall)
  );

  arb_bus_mon #(.MSG_BITS(MSG_BITS), .IDLE_BITS(IDLE_BITS)) u_mon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise),
    .bit_i (line_s[0]),
    .idle_o(bus_idle)
  );

  arb_tx #(.ID_W(ID_W), .DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .bit_i      (line_s[0]),
    .idle_i     (bus_idle),
    .req_i      (req_i),
    .id_i       (id_i),
    .data_i     (data_i),
    .drive_low_o(drive_low_o),
    .won_o      (won_o),
    .lost_o     (lost_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/wired_and_arbiter_chk.sv
module wired_and_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic drive_low_i,
  input logic won_i,
  input logic lost_i,
  input logic done_i,
  input logic err_i,
  input logic bus_idle_i
);
  AST_STATUS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_i, lost_i, err_i})); // R4
  AST_DONE_AFTER_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(won_i)); // R3
  AST_LOST_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |-> (!drive_low_i && !won_i)); // R4
  AST_ERR_IN_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> $past(won_i)); // R9
  AST_WON_BUS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won_i |-> !bus_idle_i); // R8
  AST_WON_ENDS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(won_i) |-> (done_i || err_i)); // R8
endmodule

bind wired_and_arbiter wired_and_arbiter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .drive_low_i(drive_low_o),
  .won_i      (won_o),
  .lost_i     (lost_o),
  .done_i     (done_o),
  .err_i      (err_o),
  .bus_idle_i (bus_idle)
);

// File: tb/wired_and_arbiter_bench.sv
module wired_and_arbiter_bench;
  localparam int CLK_P     = 10;
  localparam int SCL_HALF  = 6 * CLK_P;
  localparam int ID_W      = 4;
  localparam int DATA_W    = 8;
  localparam int IDLE_BITS = 2;
  localparam int N         = 3;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1;
  logic [N-1:0] req = '0, drv, won, lost, done, err;
  logic [ID_W-1:0]   ids [N];
  logic [DATA_W-1:0] dat [N];
  logic sda_bus;
  int total = 0, bad = 0;
  int done_n [N], lost_n [N], err_n [N];

  always #(CLK_P/2) clk = ~clk;
  always #(SCL_HALF) scl = ~scl;
  assign sda_bus = ~|drv;

  for (genvar g = 0; g < N; g++) begin : g_node
    wired_and_arbiter #(.ID_W(ID_W), .DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS))
      u_wired_and_arbiter (
      .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .req_i(req[g]), .id_i(ids[g]), .data_i(dat[g]),
      .drive_low_o(drv[g]), .won_o(won[g]), .lost_o(lost[g]),
      .done_o(done[g]), .err_o(err[g]));
  end

  always @(negedge clk) if (rst_n)
    for (int i = 0; i < N; i++) begin
      if (done[i]) done_n[i]++;
      if (lost[i]) lost_n[i]++;
      if (err[i])  err_n[i]++;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [N-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic wait_idle();
    repeat (IDLE_BITS + 3) @(posedge scl);
  endtask

  task automatic capture(output int gap, output logic [ID_W-1:0] fid,
                         output logic [DATA_W-1:0] fdat, output logic [N-1:0] wsnap);
    gap = 0; fid = '0; fdat = '0; wsnap = '0;
    forever begin
      @(posedge scl);
      if (!sda_bus || gap > 200) break;
      gap++;
    end
    for (int b = 0; b < ID_W; b++) begin @(posedge scl); fid = {fid[ID_W-2:0], sda_bus}; end
    for (int b = 0; b < DATA_W; b++) begin
      @(posedge scl); fdat = {fdat[DATA_W-2:0], sda_bus};
      if (b == 2) wsnap = won;
    end
  endtask

  function automatic int lowest(input logic [N-1:0] m);
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (w < 0 || ids[i] < ids[w])) w = i;
    return w;
  endfunction

  task automatic snap(output int d [N], output int l [N], output int e [N]);
    for (int i = 0; i < N; i++) begin d[i] = done_n[i]; l[i] = lost_n[i]; e[i] = err_n[i]; end
  endtask

  // contend with mask m; frames must come out in ascending id order
  task automatic round(input logic [N-1:0] m, input bit chk_first_gap);
    int gap, w, d0 [N], l0 [N], e0 [N], rank [N];
    logic [ID_W-1:0] fid; logic [DATA_W-1:0] fdat; logic [N-1:0] ws;
    logic [N-1:0] rem = m;
    int k = 0;
    snap(d0, l0, e0);
    fire(m);
    while (rem != '0) begin
      w = lowest(rem);
      rank[w] = k;
      capture(gap, fid, fdat, ws);
      chk(fid == ids[w], "R3 winner id", fid, ids[w]);
      chk(fdat == dat[w], "R2 payload", fdat, dat[w]);
      chk(ws == (N'(1) << w), "R8 won_o one-hot", ws, N'(1) << w);
      if (k > 0 || chk_first_gap) chk(gap == IDLE_BITS, "R7 idle gap", gap, IDLE_BITS);
      rem[w] = 1'b0; k++;
    end
    wait_idle();
    for (int i = 0; i < N; i++) if (m[i]) begin
      chk(done_n[i] - d0[i] == 1, "R3 done pulse", done_n[i] - d0[i], 1);
      chk(lost_n[i] - l0[i] == rank[i], "R5 loss then retry", lost_n[i] - l0[i], rank[i]);
      chk(err_n[i] == e0[i], "R4 no err", err_n[i] - e0[i], 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap, d0 [N], l0 [N], e0 [N];
    logic [ID_W-1:0] fid; logic [DATA_W-1:0] fdat; logic [N-1:0] ws;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < N; i++) begin ids[i] = ID_W'(i + 1); dat[i] = '0; end
    @(negedge scl); repeat (2) @(negedge clk);
    chk(drv == '0 && won == '0 && lost == '0 && done == '0 && err == '0,
        "R1 reset outputs", {drv, won, lost, done, err}, 0);
    rst_n = 1'b1;
    // R1: request right after reset waits IDLE_BITS recessive bits
    ids[0] = 4'hA; dat[0] = 8'h5C;
    round(3'b001, 1'b1);

    // R6 R10: late request with higher priority waits; second req ignored
    wait_idle();
    ids[0] = 4'h9; dat[0] = 8'hC3; ids[1] = 4'h2; dat[1] = 8'hA5;
    snap(d0, l0, e0);
    fire(3'b001);
    fork
      capture(gap, fid, fdat, ws);
      begin
        repeat (5) @(posedge scl);
        fire(3'b010);
        dat[1] = 8'h0F;
        fire(3'b010);
      end
    join
    chk(fid == 4'h9, "R6 busy frame intact", fid, 9);
    chk(fdat == 8'hC3, "R6 busy payload", fdat, 8'hC3);
    capture(gap, fid, fdat, ws);
    chk(fid == 4'h2, "R6 late node follows", fid, 2);
    chk(fdat == 8'hA5, "R10 first payload kept", fdat, 8'hA5);
    chk(gap == IDLE_BITS, "R7 gap after busy", gap, IDLE_BITS);
    wait_idle();
    chk(lost_n[1] == l0[1], "R6 late node never lost", lost_n[1] - l0[1], 0);

    // R9: duplicate ids collide in the payload
    ids[0] = 4'h5; dat[0] = 8'hFF; ids[1] = 4'h5; dat[1] = 8'h00;
    snap(d0, l0, e0);
    fire(3'b011);
    capture(gap, fid, fdat, ws);
    chk(fdat == 8'h00, "R9 dominant payload survives", fdat, 0);
    capture(gap, fid, fdat, ws);
    chk(fdat == 8'hFF, "R9 errored node retries", fdat, 8'hFF);
    chk(gap == IDLE_BITS, "R9 retry gap", gap, IDLE_BITS);
    wait_idle();
    chk(err_n[0] - e0[0] == 1, "R9 err pulse", err_n[0] - e0[0], 1);
    chk(err_n[1] == e0[1], "R9 no err on survivor", err_n[1] - e0[1], 0);
    chk(done_n[0] - d0[0] == 1 && done_n[1] - d0[1] == 1, "R9 both done",
        done_n[0] - d0[0] + done_n[1] - d0[1], 2);

    // directed: ids differing only in the LSB
    ids[0] = 4'h7; ids[1] = 4'h6; ids[2] = 4'hF; dat[0] = 8'h81; dat[1] = 8'h7E; dat[2] = 8'h00;
    round(3'b111, 1'b0);

    // random contention rounds
    for (int r = 0; r < 10; r++) begin
      logic [N-1:0] m;
      m = N'($urandom_range(1, (1 << N) - 1));
      for (int i = 0; i < N; i++) begin
        bit dup;
        do begin
          ids[i] = ID_W'($urandom);
          dup = 0;
          for (int j = 0; j < i; j++) if (ids[j] == ids[i]) dup = 1;
        end while (dup);
        dat[i] = DATA_W'($urandom);
      end
      round(m, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule